// File: doc/BRIEF.md
# GPIO Bank Interrupt Route Mapper

This block sits between the pin controllers of one GPIO bank and the bank's interrupt outputs. Each port of the bank delivers a vector of pending-interrupt bits, one per pin. For every port and every output line there is a route mask with one bit per pin. A pin's pending bit reaches an output line when the mask bit for that pin, port and line is set. One pin can therefore drive any subset of the output lines. Each output line is the OR of all routed pending bits across all ports, and it is registered once.

Software sets up the routing through a simple register bus. The bus has single-cycle write and read strobes, a byte address and a read-data register that is valid one cycle after the read strobe. A bank security register holds a write-lock and a read-lock. Each lock is set by software and stays set until reset. The write-lock freezes the routing. The read-lock hides the routing from reads. A per-port status register shows the raw pending bits. After reset every route mask is zero, so no interrupt reaches an output until software writes the routing, for example all pins of each port onto line 0.

Top module: `gpio_irq_router`

## Requirements
- R1: After a synchronous active-high reset, every route mask is zero, both locks are clear, `irq_o` is zero and `bus_rdata_o` is zero. While all masks are zero, `irq_o` stays zero for any pending pattern.
- R2: `irq_o[x]` equals, one clock after the inputs are presented, the OR over all ports p of (`pend_i` bits of port p AND route mask of port p, line x). Port p occupies `pend_i[p*PINS +: PINS]`.
- R3: The route mask for port p and line x is at byte address 0x14 + p*0x20 + x*4. A write stores `bus_wdata_i[PINS-1:0]` and ignores the upper bits. A read returns the mask zero-extended on `bus_rdata_o` in the cycle after the read strobe.
- R4: The security register is at address 0x0C. Bit 28 is the write-lock and bit 27 is the read-lock. Writing 1 to a lock bit sets that lock. Writing 0 does not clear it; only reset clears it. A read returns both lock bits in those positions and zero elsewhere.
- R5: While the write-lock is set, writes to the route masks are ignored and the routing is unchanged.
- R6: While the read-lock is set, reads of the route masks return zero. Routing to `irq_o` is unaffected.
- R7: A read of the status register at 0x100 + 4*p returns port p's `pend_i` bits, as sampled in the read cycle, in bits [PINS-1:0]. This register is not affected by either lock.
- R8: Reads of any other address return zero. Writes to any other address change no state.
- R9: A pin whose bit is set in the masks of several lines asserts all of those lines at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_PORTS*PINS | Pending bits per port, port p at [p*PINS +: PINS] |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe, zero otherwise |
| irq_o | output | NUM_LINES | Registered bank interrupt lines |

## Verification
The routing is first tried with no routing at all. An all-ones pending pattern must then produce silence, which separates a mask that really is cleared at reset from one that is not. The next patterns are distinct per-route mask values with junk in the upper data bits, and a single pending pin routed onto two lines. These show that each address reaches its own mask and that one pin can fan out to several lines. Long stretches of random pending patterns are also run under several routing states, including default routing of every pin onto line 0. Each pending pattern is compared against a behavioural model every clock, which exposes wrong port or line indexing, a missing OR term, or a latency off by one. The lock tests write new masks after the write-lock is set and read them after the read-lock is set. Writes to the locks' own register with zero data check that the locks stay set. Misaligned and out-of-range addresses check that unmapped accesses do nothing.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;
  // Register layout; offsets are byte addresses within the bank window.
  localparam int SEC_OFS     = 'h0C;
  localparam int WLOCK_BIT   = 28;
  localparam int RLOCK_BIT   = 27;
  localparam int ROUTE_BASE  = 'h14;
  localparam int PORT_STRIDE = 'h20;
  localparam int LINE_STRIDE = 4;
  localparam int STAT_BASE   = 'h100;
  localparam int STAT_STRIDE = 4;
  localparam int MAX_LINES   = PORT_STRIDE / LINE_STRIDE;
endpackage

// File: rtl/gpio_route_decode.sv
module gpio_route_decode
  import gpio_route_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]              addr_i,
  output logic                           sec_hit_o,
  output logic [NUM_PORTS*NUM_LINES-1:0] route_hit_o,
  output logic [NUM_PORTS-1:0]           stat_hit_o
);
  localparam logic [ADDR_W-1:0] SEC_A = ADDR_W'(SEC_OFS);

  assign sec_hit_o = (addr_i == SEC_A);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      localparam logic [ADDR_W-1:0] RA =
        ADDR_W'(ROUTE_BASE + p*PORT_STRIDE + l*LINE_STRIDE);
      assign route_hit_o[p*NUM_LINES+l] = (addr_i == RA);
    end
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_BASE + p*STAT_STRIDE);
    assign stat_hit_o[p] = (addr_i == SA);
  end

  // R3
  always_comb begin
    decode_onehot_chk: assert ($onehot0({sec_hit_o, route_hit_o, stat_hit_o}));
  end
endmodule

// File: rtl/gpio_route_regs.sv
module gpio_route_regs
  import gpio_route_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 8,
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en_i,
  input  logic                                rd_en_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  input  logic [NUM_PORTS*PINS-1:0]           pend_i,
  input  logic                                sec_hit_i,
  input  logic [NUM_PORTS*NUM_LINES-1:0]      route_hit_i,
  input  logic [NUM_PORTS-1:0]                stat_hit_i,
  output logic [NUM_PORTS*NUM_LINES*PINS-1:0] mask_o,
  output logic [DATA_W-1:0]                   rdata_o
);
  localparam int NUM_ROUTES = NUM_PORTS * NUM_LINES;

  logic [PINS-1:0]   mask_q [NUM_ROUTES];
  logic              wlock_q, rlock_q;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  // One mask register per (port, line); writes blocked by the write-lock.
  for (genvar r = 0; r < NUM_ROUTES; r++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst)
        mask_q[r] <= '0;
      else if (wr_en_i && route_hit_i[r] && !wlock_q)
        mask_q[r] <= wdata_i[PINS-1:0];
    end
    assign mask_o[r*PINS +: PINS] = mask_q[r];
  end

  // Locks are set-only until reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      wlock_q <= 1'b0;
      rlock_q <= 1'b0;
    end else if (wr_en_i && sec_hit_i) begin
      wlock_q <= wlock_q | wdata_i[WLOCK_BIT];
      rlock_q <= rlock_q | wdata_i[RLOCK_BIT];
    end
  end

  always_comb begin
    rd_val = '0;
    if (sec_hit_i) begin
      rd_val[WLOCK_BIT] = wlock_q;
      rd_val[RLOCK_BIT] = rlock_q;
    end
    for (int r = 0; r < NUM_ROUTES; r++)
      if (route_hit_i[r] && !rlock_q)
        rd_val[PINS-1:0] = rd_val[PINS-1:0] | mask_q[r];
    for (int p = 0; p < NUM_PORTS; p++)
      if (stat_hit_i[p])
        rd_val[PINS-1:0] = rd_val[PINS-1:0] | pend_i[p*PINS +: PINS];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_en_i ? rd_val : '0;
  end
  assign rdata_o = rdata_q;

  // R5
  route_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    wlock_q |=> $stable(mask_o));
  // R4
  wlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wlock_q |=> wlock_q);
  // R4
  rlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rlock_q |=> rlock_q);
  // R6
  read_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rlock_q && (|route_hit_i)) |=> (rdata_o == '0));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !sec_hit_i && (route_hit_i == '0) && (stat_hit_i == '0))
      |=> (rdata_o == '0));
endmodule

// File: rtl/gpio_route_combine.sv
module gpio_route_combine #(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 8,
  parameter int NUM_LINES = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PORTS*PINS-1:0]           pend_i,
  input  logic [NUM_PORTS*NUM_LINES*PINS-1:0] mask_i,
  output logic [NUM_LINES-1:0]                irq_o
);
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] irq_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [PINS-1:0] acc;
    always_comb begin
      acc = '0;
      for (int p = 0; p < NUM_PORTS; p++)
        acc = acc | (pend_i[p*PINS +: PINS] & mask_i[(p*NUM_LINES+l)*PINS +: PINS]);
    end
    assign hit[l] = |acc;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= hit;
  end
  assign irq_o = irq_q;

  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_i == '0) |=> (irq_q == '0));
  // R1
  unrouted_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> (irq_q == '0));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_route_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 8,
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PORTS*PINS-1:0] pend_i,
  input  logic                      bus_wr_i,
  input  logic                      bus_rd_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]         bus_wdata_i,
  output logic [DATA_W-1:0]         bus_rdata_o,
  output logic [NUM_LINES-1:0]      irq_o
);
  localparam int NUM_ROUTES = NUM_PORTS * NUM_LINES;
  localparam int MASK_W     = NUM_ROUTES * PINS;

  logic                  sec_hit;
  logic [NUM_ROUTES-1:0] route_hit;
  logic [NUM_PORTS-1:0]  stat_hit;
  logic [MASK_W-1:0]     mask_flat;

  gpio_route_decode #(
    .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr_i      (bus_addr_i),
    .sec_hit_o   (sec_hit),
    .route_hit_o (route_hit),
    .stat_hit_o  (stat_hit)
  );

  gpio_route_regs #(
    .NUM_PORTS(NUM_PORTS), .PINS(PINS), .NUM_LINES(NUM_LINES), .DATA_W(DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (bus_wr_i),
    .rd_en_i     (bus_rd_i),
    .wdata_i     (bus_wdata_i),
    .pend_i      (pend_i),
    .sec_hit_i   (sec_hit),
    .route_hit_i (route_hit),
    .stat_hit_i  (stat_hit),
    .mask_o      (mask_flat),
    .rdata_o     (bus_rdata_o)
  );

  gpio_route_combine #(
    .NUM_PORTS(NUM_PORTS), .PINS(PINS), .NUM_LINES(NUM_LINES)
  ) u_combine (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_i),
    .mask_i (mask_flat),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int PN = 8;
  localparam int NL = 8;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int PW = NP * PN;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] pend = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NL-1:0] irq;

  int    cmp_cnt = 0;
  int    bad_cnt = 0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_router #(
    .NUM_PORTS(NP), .PINS(PN), .NUM_LINES(NL), .ADDR_W(AW), .DATA_W(DW)
  ) dut_i (
    .clk(clk), .rst(rst), .pend_i(pend), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // Behavioural reference model
  logic [PN-1:0] m_mask [NP][NL];
  logic          m_wl, m_rl;
  logic [NL-1:0] exp_irq = '0;
  logic [DW-1:0] exp_rdata = '0;
  logic [NL-1:0] n_irq;
  logic [DW-1:0] n_rd;
  int            a, rel;

  function automatic bit is_route(input int ad);
    int off;
    off = ad - 'h14;
    return (ad >= 'h14) && (off < NP*'h20) && ((off % 'h20) < NL*4) && ((off % 4) == 0);
  endfunction

  function automatic bit is_stat(input int ad);
    return (ad >= 'h100) && (ad < 'h100 + 4*NP) && ((ad % 4) == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++)
        for (int l = 0; l < NL; l++) m_mask[p][l] = '0;
      m_wl = 1'b0; m_rl = 1'b0;
      exp_irq = '0; exp_rdata = '0;
    end else begin
      for (int l = 0; l < NL; l++) begin
        n_irq[l] = 1'b0;
        for (int p = 0; p < NP; p++)
          for (int b = 0; b < PN; b++)
            if (pend[p*PN+b] && m_mask[p][l][b]) n_irq[l] = 1'b1;
      end
      a = int'(addr);
      rel = a - 'h14;
      n_rd = '0;
      if (rd) begin
        if (a == 'h0C) begin n_rd[28] = m_wl; n_rd[27] = m_rl; end
        else if (is_route(a)) begin
          if (!m_rl) n_rd[PN-1:0] = m_mask[rel/'h20][(rel%'h20)/4];
        end else if (is_stat(a))
          n_rd[PN-1:0] = pend[((a-'h100)/4)*PN +: PN];
      end
      if (wr) begin
        if (a == 'h0C) begin
          m_wl = m_wl | wdata[28];
          m_rl = m_rl | wdata[27];
        end else if (is_route(a) && !m_wl)
          m_mask[rel/'h20][(rel%'h20)/4] = wdata[PN-1:0];
      end
      exp_irq = n_irq;
      exp_rdata = n_rd;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_cnt++;
    if (irq !== exp_irq) begin
      bad_cnt++;
      $display("FAIL %s irq_o actual=%h expected=%h", phase, irq, exp_irq);
    end
    cmp_cnt++;
    if (rdata !== exp_rdata) begin
      bad_cnt++;
      $display("FAIL %s bus_rdata_o actual=%h expected=%h", phase, rdata, exp_rdata);
    end
  endtask

  task automatic bus_write(input int ad, input logic [DW-1:0] d);
    wr = 1'b1; addr = AW'(ad); wdata = d;
    tick();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input int ad);
    rd = 1'b1; addr = AW'(ad);
    tick();
    rd = 1'b0;
  endtask

  task automatic random_pend(input int n);
    for (int i = 0; i < n; i++) begin
      pend = PW'($urandom());
      if ((i % 7) == 3) pend = '0;
      tick();
    end
  endtask

  function automatic int raddr(input int p, input int l);
    return 'h14 + p*'h20 + l*4;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    bad_cnt++;
    $display("FAIL %s watchdog actual=timeout expected=completion", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, bad_cnt);
    $finish;
  end

  initial begin
    // R1: reset state
    phase = "R1 reset";
    repeat (3) tick();
    rst = 1'b0;
    tick();
    bus_read(raddr(0, 0));
    bus_read('h0C);
    pend = '1;
    repeat (4) tick();
    pend = '0;
    tick();

    // R3: distinct masks per route with junk upper bits, then read back
    phase = "R3 route map";
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++)
        bus_write(raddr(p, l), 32'hABCD_0000 | DW'((p*37 + l*11 + 1) & 'hFF));
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++)
        bus_read(raddr(p, l));

    // R2: random pending patterns under the mixed routing
    phase = "R2 mixed routing";
    random_pend(200);

    // R2: default routing, every pin of every port onto line 0 only
    phase = "R2 default line0";
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++)
        bus_write(raddr(p, l), (l == 0) ? DW'((1 << PN) - 1) : '0);
    random_pend(100);
    for (int p = 0; p < NP; p++) begin
      pend = '0;
      pend[p*PN + (p % PN)] = 1'b1;
      tick();
    end
    pend = '0;
    tick();

    // R9: one pin fanned out to two lines
    phase = "R9 fan-out";
    bus_write(raddr(2, 5), 32'h10);
    bus_write(raddr(2, 6), 32'h10);
    pend = '0;
    pend[2*PN + 4] = 1'b1;
    repeat (3) tick();
    pend = '0;
    repeat (2) tick();

    // R7: status readback
    phase = "R7 status";
    for (int k = 0; k < 3; k++)
      for (int p = 0; p < NP; p++) begin
        pend = PW'($urandom());
        bus_read('h100 + 4*p);
      end

    // R8: unmapped and misaligned addresses
    phase = "R8 unmapped";
    bus_write('h08, '1);
    bus_write('h15, '1);
    bus_write('h14 + NP*'h20, '1);
    bus_write('h200, '1);
    bus_read('h08);
    bus_read('h15);
    bus_read('h14 + NP*'h20);
    bus_read('h104 + 4*NP);
    for (int l = 0; l < NL; l++) bus_read(raddr(0, l));
    bus_read('h0C);

    // R5: write-lock freezes routing
    phase = "R5 write lock";
    bus_write('h0C, 32'h1000_0000);
    bus_read('h0C);
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++)
        bus_write(raddr(p, l), '1);
    for (int p = 0; p < NP; p++) bus_read(raddr(p, 0));
    bus_read(raddr(1, 3));
    random_pend(50);

    // R4: zero write does not clear a lock
    phase = "R4 sticky lock";
    bus_write('h0C, '0);
    bus_read('h0C);

    // R6: read-lock hides masks, routing still active
    phase = "R6 read lock";
    bus_write('h0C, 32'h0800_0000);
    bus_read('h0C);
    for (int p = 0; p < NP; p++) bus_read(raddr(p, 0));
    bus_read(raddr(2, 5));
    random_pend(50);
    phase = "R7 status under lock";
    for (int p = 0; p < NP; p++) begin
      pend = PW'($urandom());
      bus_read('h100 + 4*p);
    end

    // R1: second reset clears locks and routing
    phase = "R1 re-reset";
    rst = 1'b1;
    pend = '1;
    repeat (2) tick();
    rst = 1'b0;
    repeat (2) tick();
    bus_read('h0C);
    bus_read(raddr(0, 0));
    pend = '0;
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, bad_cnt);
    $finish;
  end
endmodule